// File: doc/BRIEF.md
# Four-Lane Serial-to-Parallel Output Driver Core

This block is the digital core of a wide output driver. Serial data arrives on several inputs at once. Each input feeds its own shift lane, and all lanes share one clock, so a whole group of bits enters on every rising edge. With the default parameters, four lanes of twenty stages give eighty output channels. A direction input selects whether each lane shifts toward its high end or toward its low end.

A level-sensitive load control sits between the lanes and the outputs. While it is high, the outputs follow the lanes. While it is low, the outputs hold the last captured value. After this stage, an invert control and a blanking control condition every channel. A cascade output presents the lane bit that is about to leave the device, so several devices can be chained.

Top module: `quad_sipo_driver`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every shift stage and every held bit. After reset, with `load` high and `blank` and `invert` low, all outputs read 0.
- R2: With `dir` = 0, each rising edge moves every lane one stage toward the higher channel numbers. Input `sin[k]` enters 0-based channel k. Channel c belongs to lane c mod LANES at stage c / LANES.
- R3: With `dir` = 1, each lane moves one stage toward the lower channel numbers. Input `sin[k]` enters channel CH-LANES+k.
- R4: With `dir` = 0, `sout` equals the current content of the highest channel, CH-1.
- R5: With `dir` = 1, `sout` equals the current content of channel 0.
- R6: While `load` is high, each output channel follows its shift stage without waiting for a clock edge.
- R7: While `load` is low, the held bits do not change. The outputs then stay constant as long as `blank` and `invert` do not change.
- R8: When `invert` is 1 and `blank` is 0, each output is the complement of its stored bit. When `invert` is 0, the output is the stored bit unchanged.
- R9: When `blank` is 1, all outputs are 0, whatever the values of `invert` and the stored bits.
- R10: Shifting does not depend on `load`, `blank` or `invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the lanes advance on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sin | input | LANES | One serial data bit per lane |
| dir | input | 1 | Shift direction: 0 shifts toward high channels, 1 toward low channels |
| load | input | 1 | Level-sensitive load: 1 makes the outputs follow the lanes, 0 holds them |
| blank | input | 1 | Forces all outputs to 0 |
| invert | input | 1 | Complements all outputs when blanking is off |
| q | output | LANES*DEPTH | Conditioned parallel outputs, bit c is channel c |
| sout | output | 1 | Cascade output: the bit that leaves in the selected direction |

## Verification
The bench builds the block with four lanes of six stages each. It keeps the four-way interleave of the inputs, but with only six stages a bit crosses a whole lane and appears on the cascade output within a handful of cycles. This makes the exit-end behaviour and direction reversals in the middle of a lane cheap to reach many times. Because the model holds one queue per lane, every channel position is exercised under both directions, with the load control both held and transparent, and with every combination of blanking and inversion.

// File: rtl/quad_sipo_driver.sv
module quad_sipo_driver #(
  parameter int LANES = 4,
  parameter int DEPTH = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       sin,
  input  logic                   dir,
  input  logic                   load,
  input  logic                   blank,
  input  logic                   invert,
  output logic [LANES*DEPTH-1:0] q,
  output logic                   sout
);
  localparam int CH = LANES * DEPTH;

  logic [CH-1:0] sr, sr_nx, lat, src;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic from_lo, from_hi;
    if (c < LANES) begin : g_lo
      assign from_lo = sin[c];
    end else begin : g_lo
      assign from_lo = sr[c-LANES];
    end
    if (c >= CH - LANES) begin : g_hi
      assign from_hi = sin[c-(CH-LANES)];
    end else begin : g_hi
      assign from_hi = sr[c+LANES];
    end
    assign sr_nx[c] = dir ? from_hi : from_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      lat <= '0;
    end else begin
      sr <= sr_nx;
      if (load) lat <= sr_nx;
    end
  end

  assign src  = load ? sr : lat;
  assign q    = blank ? '0 : (src ^ {CH{invert}});
  assign sout = dir ? sr[0] : sr[CH-1];
endmodule

// File: rtl/quad_sipo_chk.sv
module quad_sipo_chk #(
  parameter int LANES = 4,
  parameter int DEPTH = 20
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       sin,
  input logic                   dir,
  input logic                   load,
  input logic                   blank,
  input logic                   invert,
  input logic [LANES*DEPTH-1:0] sr,
  input logic [LANES*DEPTH-1:0] lat,
  input logic [LANES*DEPTH-1:0] q,
  input logic                   sout
);
  localparam int CH = LANES * DEPTH;

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (sr == '0 && lat == '0));

  // R2
  fwd_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !dir |=> (sr[CH-1:LANES] == $past(sr[CH-LANES-1:0]) && sr[LANES-1:0] == $past(sin)));

  // R3
  rev_shift_chk: assert property (@(posedge clk) disable iff (rst)
    dir |=> (sr[CH-LANES-1:0] == $past(sr[CH-1:LANES]) && sr[CH-1:CH-LANES] == $past(sin)));

  // R4
  fwd_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir && !$past(dir) && !$past(rst)) |-> sout == $past(sr[CH-1-LANES]));

  // R5
  rev_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    (dir && $past(dir) && !$past(rst)) |-> sout == $past(sr[LANES]));

  // R6
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !blank && !invert) |-> q == sr);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !$past(load) && !$past(rst) && $stable(blank) && $stable(invert)) |-> $stable(q));

  // R9
  blank_chk: assert property (@(posedge clk) disable iff (rst) blank |-> q == '0);
endmodule

bind quad_sipo_driver quad_sipo_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk (
  .clk(clk), .rst(rst), .sin(sin), .dir(dir), .load(load), .blank(blank),
  .invert(invert), .sr(sr), .lat(lat), .q(q), .sout(sout)
);

// File: tb/quad_sipo_driver_test.sv
module quad_sipo_driver_test;
  localparam int L  = 4;
  localparam int D  = 6;
  localparam int CH = L * D;

  logic clk = 0;
  logic rst = 1;
  logic [L-1:0] sin = '0;
  logic dir = 0, load = 1, blank = 0, invert = 0;
  logic [CH-1:0] q;
  logic sout;

  int checks = 0, fails = 0;
  bit lanes[L][$];
  logic [CH-1:0] mlat = '0;

  quad_sipo_driver #(.LANES(L), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .sin(sin), .dir(dir), .load(load),
    .blank(blank), .invert(invert), .q(q), .sout(sout)
  );

  always #10 clk = ~clk;

  function automatic logic [CH-1:0] model_regs();
    logic [CH-1:0] r;
    for (int c = 0; c < CH; c++) r[c] = lanes[c % L][c / L];
    return r;
  endfunction

  function automatic logic [CH-1:0] exp_q();
    logic [CH-1:0] s;
    s = load ? model_regs() : mlat;
    return blank ? '0 : (s ^ {CH{invert}});
  endfunction

  task automatic step(input logic [L-1:0] s, input logic d, input logic ld,
                      input logic bl, input logic inv, input string tag);
    logic [CH-1:0] e;
    logic eo;
    sin = s; dir = d; load = ld; blank = bl; invert = inv;
    #1;
    e  = exp_q();
    eo = dir ? lanes[0][0] : lanes[L-1][D-1];
    checks++;
    if (q !== e) begin
      fails++;
      $display("FAIL %s: q=%h expected %h", tag, q, e);
    end
    checks++;
    if (sout !== eo) begin
      fails++;
      $display("FAIL %s: sout=%b expected %b", dir ? "R5" : "R4", sout, eo);
    end
    @(posedge clk);
    for (int k = 0; k < L; k++) begin
      if (rst) begin
        lanes[k].delete();
        for (int i = 0; i < D; i++) lanes[k].push_back(1'b0);
      end else if (!dir) begin
        lanes[k].push_front(s[k]);
        void'(lanes[k].pop_back());
      end else begin
        lanes[k].push_back(s[k]);
        void'(lanes[k].pop_front());
      end
    end
    if (rst) mlat = '0;
    else if (ld) mlat = model_regs();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < L; k++)
      for (int i = 0; i < D; i++) lanes[k].push_back(1'b0);
    @(negedge clk);
    step('0, 0, 1, 0, 0, "R1");
    step('1, 0, 1, 0, 0, "R1");
    rst = 0;
    step('0, 0, 1, 0, 0, "R1");
    // R2 walking pattern into each lane
    for (int i = 0; i < D + 3; i++) step(L'(1 << (i % L)), 0, 1, 0, 0, "R2");
    for (int i = 0; i < D; i++) step(L'($urandom), 0, 1, 0, 0, "R2");
    // R7 hold while lanes keep moving
    for (int i = 0; i < D + 2; i++) step(L'($urandom), 0, 0, 0, 0, "R7");
    // R6 transparent again
    for (int i = 0; i < 4; i++) step(L'($urandom), 0, 1, 0, 0, "R6");
    // R8 inversion, transparent and held
    for (int i = 0; i < 4; i++) step(L'($urandom), 0, 1, 0, 1, "R8");
    for (int i = 0; i < 4; i++) step(L'($urandom), 0, 0, 0, 1, "R8");
    // R9 blanking wins over inversion
    for (int i = 0; i < 3; i++) step(L'($urandom), 0, 1, 1, 1, "R9");
    for (int i = 0; i < 3; i++) step(L'($urandom), 0, 0, 1, 0, "R9");
    // R3 reverse shifting with walking pattern
    for (int i = 0; i < D + 3; i++) step(L'(1 << (i % L)), 1, 1, 0, 0, "R3");
    for (int i = 0; i < D; i++) step(L'($urandom), 1, 0, 0, 0, "R3");
    // R10 everything random, shifting must be unaffected
    for (int i = 0; i < 300; i++)
      step(L'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom), "R10");
    // R1 reset in the middle of traffic
    rst = 1;
    step('1, 0, 0, 0, 0, "R1");
    rst = 0;
    step('0, 0, 0, 0, 0, "R1");
    step('0, 0, 1, 0, 0, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule